// File: doc/BRIEF.md
# Receive Symbol Order Restorer

This block sits just after the byte deserializer in a serial receive path. Each clock it takes a parallel word of several symbols, each made of a data byte plus a control flag. After the deserializer comes out of reset, a symbol that the far end transmitted in the least significant slot may arrive in any slot. When the block is armed, it hunts for a programmable ordering symbol. When that symbol turns up in a higher slot, the block fills the rest of the current output word with a programmable pad symbol. The ordering symbol then opens the next output word, and every later word keeps that symbol offset.

The block can be armed in one of two ways, chosen at reset. In manual mode it is armed by a rising edge on a request input. In sync mode it is armed by a rising edge of the word aligner's lock status, so ordering starts as soon as word alignment completes. A status output reports a successful ordering, and it does so even when the symbol was already in place and no pad was needed. The ordering symbol, the pad symbol, the arming source and the comparison width are sampled while reset is held.

Top module: `rx_symbol_orderer`

## Requirements
- R1: While `rst` is high, the outputs clear, the symbol offset returns to zero and the configuration inputs are captured. Configuration changes after reset is released have no effect until the next reset.
- R2: With `cfg_sync_mode`=0, the block arms only in a cycle where `rx_order_req` is high and was low in the previous cycle. Holding the request high does not arm it again.
- R3: With `cfg_sync_mode`=1, the block arms only on a low-to-high change of `rx_sync`, and `rx_order_req` is ignored.
- R4: While not armed, the ordering symbol passes through unchanged and no pad symbol is inserted.
- R5: While armed, the first input word containing the ordering symbol is acted on. If several slots match, the lowest slot k wins. With current offset o, the output word built from that input has its slots o+k through NSYM-1 replaced by the pad symbol (NSYM-k pads at offset 0). The next output word carries the ordering symbol in slot 0. With o=0 and k=0, nothing is padded.
- R6: After a match in slot k, the offset becomes NSYM-k, or stays 0 when o=0 and k=0. Each later output word is the top o symbols of the previous input word, in slots 0..o-1, followed by the low NSYM-o symbols of the current input word. The offset changes only on a match while armed.
- R7: `ord_status` clears on reset and in the cycle after an arming edge. It rises together with the output word built from the matching input, including the case where no pad was needed. It stays high until the next arming edge.
- R8: With `cfg_cmp_ctrl`=1, a slot matches only if both its control flag and data equal `cfg_pattern[8]` and `cfg_pattern[7:0]`. With `cfg_cmp_ctrl`=0, only the data byte is compared.
- R9: Slot j is carried on data bits [8j+7:8j] and control bit j. The pad symbol puts `cfg_pad[8]` on the control bit and `cfg_pad[7:0]` on the data. Every output word appears one clock after the input word it is built from.
- R10: If o+k exceeds NSYM, no pad is inserted. The current output is formed normally, the input symbols between that word's end and slot k are dropped, and the ordering symbol still opens the next output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while high |
| cfg_pattern | input | DW+1 | Ordering symbol {control, data} |
| cfg_pad | input | DW+1 | Pad symbol {control, data} |
| cfg_sync_mode | input | 1 | 0: armed by request edge, 1: armed by sync edge |
| cfg_cmp_ctrl | input | 1 | 1: compare control flag too, 0: data only |
| rx_data | input | NSYM*DW | Deserialized data, slot j at bits [DW*j +: DW] |
| rx_ctrl | input | NSYM | Control flag per slot |
| rx_sync | input | 1 | Word aligner lock status |
| rx_order_req | input | 1 | Manual ordering request |
| ord_data | output | NSYM*DW | Reordered data |
| ord_ctrl | output | NSYM | Reordered control flags |
| ord_status | output | 1 | Ordering achieved |

## Verification
On every cycle the assertions check the arming rules: only a true edge of the selected source arms the block, and a held request or the unselected source never does. They also check that the offset stays within 0..NSYM and only moves while a hunt is open, and that the status clears on arming, rises only after a hunt and holds until the next arm. Only the bench scenarios can show the data-path results. These are the exact pad count and pad placement for each slot position, the ordering symbol appearing in slot 0 of the following word, the straddled words that follow, the dropping of symbols when the new offset overruns, and the effect of the comparison width and of configuration sampled at reset.

// File: rtl/symord_pkg.sv
package symord_pkg;
    typedef enum logic {
        SRC_MANUAL = 1'b0,
        SRC_SYNC   = 1'b1
    } trig_src_e;
endpackage

// File: rtl/symord_trigger.sv
// Arming-edge detector: selects request or sync level, flags a low-to-high change.
module symord_trigger
    import symord_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trig_src_e src,
    input  logic      req,
    input  logic      sync,
    output logic      fire
);
    typedef struct packed {
        logic req;
        logic sync;
    } lvl_t;

    lvl_t lvl_d, lvl_q;
    logic now_lvl, old_lvl;

    always_comb begin
        // previous levels track inputs even in reset: a level already high at release is no edge
        lvl_d.req  = req;
        lvl_d.sync = sync;
        now_lvl    = (src == SRC_SYNC) ? sync : req;
        old_lvl    = (src == SRC_SYNC) ? lvl_q.sync : lvl_q.req;
        fire       = !rst && now_lvl && !old_lvl;
    end

    always_ff @(posedge clk) begin
        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/symord_finder.sv
// Locates the ordering symbol; lowest matching slot wins.
module symord_finder #(
    parameter int NSYM  = 4,
    parameter int DW    = 8,
    localparam int SW    = DW + 1,
    localparam int IDX_W = (NSYM > 1) ? $clog2(NSYM) : 1
) (
    input  logic [NSYM*SW-1:0] word,
    input  logic [SW-1:0]      pattern,
    input  logic               cmp_ctrl,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);
    logic [NSYM-1:0] slot_hit;

    for (genvar g = 0; g < NSYM; g++) begin : g_cmp
        assign slot_hit[g] = cmp_ctrl ? (word[g*SW +: SW] == pattern)
                                      : (word[g*SW +: DW] == pattern[DW-1:0]);
    end

    always_comb begin
        hit = |slot_hit;
        idx = '0;
        for (int i = NSYM - 1; i >= 0; i--) begin
            if (slot_hit[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/symord_window.sv
// Builds one output word from the previous and current input words at a symbol offset,
// replacing slots from fill_from upward with the pad symbol.
module symord_window #(
    parameter int NSYM  = 4,
    parameter int DW    = 8,
    localparam int SW    = DW + 1,
    localparam int OFS_W = $clog2(NSYM + 1)
) (
    input  logic [NSYM*SW-1:0] prev_word,
    input  logic [NSYM*SW-1:0] cur_word,
    input  logic [OFS_W-1:0]   ofs,
    input  logic [OFS_W-1:0]   fill_from,
    input  logic [SW-1:0]      pad,
    output logic [NSYM*SW-1:0] out_word
);
    always_comb begin
        out_word = '0;
        for (int j = 0; j < NSYM; j++) begin
            if (j >= int'(fill_from)) begin
                out_word[j*SW +: SW] = pad;
            end else if (NSYM - int'(ofs) + j < NSYM) begin
                out_word[j*SW +: SW] = prev_word[(NSYM - int'(ofs) + j)*SW +: SW];
            end else begin
                out_word[j*SW +: SW] = cur_word[(j - int'(ofs))*SW +: SW];
            end
        end
    end
endmodule

// File: rtl/rx_symbol_orderer.sv
module rx_symbol_orderer
    import symord_pkg::*;
#(
    parameter int NSYM = 4,
    parameter int DW   = 8,
    localparam int SW    = DW + 1,
    localparam int OFS_W = $clog2(NSYM + 1),
    localparam int IDX_W = (NSYM > 1) ? $clog2(NSYM) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SW-1:0]      cfg_pattern,
    input  logic [SW-1:0]      cfg_pad,
    input  logic               cfg_sync_mode,
    input  logic               cfg_cmp_ctrl,
    input  logic [NSYM*DW-1:0] rx_data,
    input  logic [NSYM-1:0]    rx_ctrl,
    input  logic               rx_sync,
    input  logic               rx_order_req,
    output logic [NSYM*DW-1:0] ord_data,
    output logic [NSYM-1:0]    ord_ctrl,
    output logic               ord_status
);
    typedef struct packed {
        logic [SW-1:0]      pat;
        logic [SW-1:0]      pad;
        trig_src_e          src;
        logic               cmp_ctrl;
        logic [NSYM*SW-1:0] prev;
        logic [NSYM*SW-1:0] out;
        logic [OFS_W-1:0]   ofs;
        logic               hunting;
        logic               status;
    } state_t;

    state_t st_d, st_q;

    logic [NSYM*SW-1:0] in_word;
    logic [NSYM*SW-1:0] win_word;
    logic               trig_fire;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic               order_hit;
    logic [OFS_W-1:0]   fill_from;
    logic [OFS_W-1:0]   new_ofs;

    // checker taps
    logic             hunting_w;
    logic             sync_mode_w;
    logic [OFS_W-1:0] ofs_w;
    assign hunting_w   = st_q.hunting;
    assign sync_mode_w = (st_q.src == SRC_SYNC);
    assign ofs_w       = st_q.ofs;

    for (genvar j = 0; j < NSYM; j++) begin : g_pack
        assign in_word[j*SW +: SW] = {rx_ctrl[j], rx_data[j*DW +: DW]};
        assign ord_data[j*DW +: DW] = st_q.out[j*SW +: DW];
        assign ord_ctrl[j]          = st_q.out[j*SW + DW];
    end
    assign ord_status = st_q.status;

    symord_trigger u_trig (
        .clk  (clk),
        .rst  (rst),
        .src  (st_q.src),
        .req  (rx_order_req),
        .sync (rx_sync),
        .fire (trig_fire)
    );

    symord_finder #(.NSYM(NSYM), .DW(DW)) u_find (
        .word     (in_word),
        .pattern  (st_q.pat),
        .cmp_ctrl (st_q.cmp_ctrl),
        .hit      (hit),
        .idx      (hit_idx)
    );

    // Match decision: new offset and first padded slot
    always_comb begin
        order_hit = st_q.hunting && hit && !trig_fire;
        fill_from = OFS_W'(NSYM);
        new_ofs   = st_q.ofs;
        if (order_hit && (st_q.ofs != '0 || hit_idx != '0)) begin
            new_ofs = OFS_W'(NSYM) - OFS_W'(hit_idx);
            if (int'(st_q.ofs) + int'(hit_idx) < NSYM) begin
                fill_from = st_q.ofs + OFS_W'(hit_idx);
            end
        end
    end

    symord_window #(.NSYM(NSYM), .DW(DW)) u_win (
        .prev_word (st_q.prev),
        .cur_word  (in_word),
        .ofs       (st_q.ofs),
        .fill_from (fill_from),
        .pad       (st_q.pad),
        .out_word  (win_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = in_word;
        st_d.out  = win_word;
        st_d.ofs  = new_ofs;
        if (trig_fire) begin
            st_d.hunting = 1'b1;
            st_d.status  = 1'b0;
        end else if (order_hit) begin
            st_d.hunting = 1'b0;
            st_d.status  = 1'b1;
        end
        if (rst) begin
            st_d          = '0;
            st_d.pat      = cfg_pattern;
            st_d.pad      = cfg_pad;
            st_d.src      = cfg_sync_mode ? SRC_SYNC : SRC_MANUAL;
            st_d.cmp_ctrl = cfg_cmp_ctrl;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/symord_checker.sv
module symord_checker #(
    parameter int NSYM  = 4,
    parameter int OFS_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_order_req,
    input logic             rx_sync,
    input logic             sync_mode,
    input logic             fire,
    input logic             hunting,
    input logic             status,
    input logic [OFS_W-1:0] ofs
);
    p_manual_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (!sync_mode && fire) |-> (rx_order_req && !$past(rx_order_req)));

    p_manual_level_r2: assert property (@(posedge clk) disable iff (rst)
        (!sync_mode && rx_order_req && $past(rx_order_req)) |-> !fire);

    p_sync_edge_r3: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && fire) |-> (rx_sync && !$past(rx_sync)));

    p_ofs_range_r6: assert property (@(posedge clk) disable iff (rst)
        int'(ofs) <= NSYM);

    p_ofs_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !hunting |=> $stable(ofs));

    p_arm_clears_r7: assert property (@(posedge clk) disable iff (rst)
        fire |=> (hunting && !status));

    p_status_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (status && !fire) |=> status);

    p_status_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(status) |-> $past(hunting));
endmodule

bind rx_symbol_orderer symord_checker #(.NSYM(NSYM), .OFS_W(OFS_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_order_req (rx_order_req),
    .rx_sync      (rx_sync),
    .sync_mode    (sync_mode_w),
    .fire         (trig_fire),
    .hunting      (hunting_w),
    .status       (ord_status),
    .ofs          (ofs_w)
);

// File: tb/rx_symbol_orderer_tb.sv
`timescale 1ns/1ps
module rx_symbol_orderer_tb;
    localparam int NSYM = 4;
    localparam int DW   = 8;
    localparam int SW   = DW + 1;
    localparam logic [SW-1:0] PAT  = 9'h1BC;
    localparam logic [SW-1:0] PADA = 9'h11C;
    localparam logic [SW-1:0] PADB = 9'h1F7;

    typedef logic [NSYM-1:0][SW-1:0] wvec_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [SW-1:0]      cfg_pattern = PAT;
    logic [SW-1:0]      cfg_pad = PADA;
    logic               cfg_sync_mode = 1'b0;
    logic               cfg_cmp_ctrl = 1'b1;
    logic [NSYM*DW-1:0] rx_data = '0;
    logic [NSYM-1:0]    rx_ctrl = '0;
    logic               rx_sync = 1'b0;
    logic               rx_order_req = 1'b0;
    logic [NSYM*DW-1:0] ord_data;
    logic [NSYM-1:0]    ord_ctrl;
    logic               ord_status;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    rx_symbol_orderer #(.NSYM(NSYM), .DW(DW)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_pattern(cfg_pattern), .cfg_pad(cfg_pad),
        .cfg_sync_mode(cfg_sync_mode), .cfg_cmp_ctrl(cfg_cmp_ctrl),
        .rx_data(rx_data), .rx_ctrl(rx_ctrl),
        .rx_sync(rx_sync), .rx_order_req(rx_order_req),
        .ord_data(ord_data), .ord_ctrl(ord_ctrl), .ord_status(ord_status)
    );

    function automatic wvec_t mkw(input int base);
        wvec_t w;
        for (int j = 0; j < NSYM; j++) w[j] = {1'b0, 8'(base + j)};
        return w;
    endfunction

    // Expected straddled word at offset o (R6)
    function automatic wvec_t win(input wvec_t p, input wvec_t c, input int o);
        wvec_t r;
        for (int j = 0; j < NSYM; j++) begin
            if (j < o) r[j] = p[NSYM - o + j];
            else       r[j] = c[j - o];
        end
        return r;
    endfunction

    function automatic wvec_t got();
        wvec_t r;
        for (int j = 0; j < NSYM; j++) r[j] = {ord_ctrl[j], ord_data[j*DW +: DW]};
        return r;
    endfunction

    task automatic step(input wvec_t w);
        @(negedge clk);
        for (int j = 0; j < NSYM; j++) begin
            rx_data[j*DW +: DW] = w[j][DW-1:0];
            rx_ctrl[j]          = w[j][DW];
        end
        @(posedge clk);
        #1;
    endtask

    task automatic chk_word(input string req, input wvec_t exp);
        wvec_t act = got();
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s word act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s status act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [SW-1:0] pat, input logic [SW-1:0] pad,
                            input logic smode, input logic cmpc);
        @(negedge clk);
        rst = 1'b1; cfg_pattern = pat; cfg_pad = pad;
        cfg_sync_mode = smode; cfg_cmp_ctrl = cmpc;
        rx_order_req = 1'b0; rx_sync = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        do_reset(PAT, PADA, 1'b0, 1'b1);
        chk_word("R1", '0);
        chk_bit("R1", ord_status, 1'b0);
    endtask

    // Pattern at slot k from offset 0 (R5, R6, R7)
    task automatic t_offset(input int k);
        wvec_t w1, w2, w3, e1;
        do_reset(PAT, PADA, 1'b0, 1'b1);
        w1 = mkw(8'h40); w1[k] = PAT;
        w2 = mkw(8'h50); w3 = mkw(8'h60);
        rx_order_req = 1'b1;
        step(mkw(8'h30));
        chk_bit("R7", ord_status, 1'b0);
        step(w1);
        for (int j = 0; j < NSYM; j++) e1[j] = (k != 0 && j >= k) ? PADA : w1[j];
        chk_word("R5", e1);
        chk_bit("R7", ord_status, 1'b1);
        step(w2);
        chk_word("R5", win(w1, w2, (NSYM - k) % NSYM));
        step(w3);
        chk_word("R6", win(w2, w3, (NSYM - k) % NSYM));
        rx_order_req = 1'b0;
    endtask

    // Held request, re-arm, no-pad success, overrun drop (R2, R7, R5, R10)
    task automatic t_rearm();
        wvec_t w1, w2, w3, w4, w5, w6;
        do_reset(PAT, PADA, 1'b0, 1'b1);
        rx_order_req = 1'b1;
        step(mkw(8'h10));
        w1 = mkw(8'h20); w1[2] = PAT;
        step(w1);                      // offset becomes 2
        w2 = mkw(8'h24); w2[1] = PAT;
        step(w2);                      // request still high: no new hunt
        chk_word("R2", win(w1, w2, 2));
        chk_bit("R2", ord_status, 1'b1);
        rx_order_req = 1'b0;
        w3 = mkw(8'h70);
        step(w3);
        rx_order_req = 1'b1;
        w4 = mkw(8'h74);
        step(w4);
        chk_bit("R7", ord_status, 1'b0);
        w5 = mkw(8'h78); w5[2] = PAT; // o+k == NSYM: already placed
        step(w5);
        chk_word("R5", win(w4, w5, 2));
        chk_bit("R7", ord_status, 1'b1);
        w6 = mkw(8'h7C);
        step(w6);
        chk_word("R6", win(w5, w6, 2));
        rx_order_req = 1'b0;
        step(mkw(8'h80));
        rx_order_req = 1'b1;
        w1 = mkw(8'h84);
        step(w1);
        w2 = mkw(8'h88); w2[3] = PAT; // o=2,k=3: overrun
        step(w2);
        chk_word("R10", win(w1, w2, 2));
        w3 = mkw(8'h8C);
        step(w3);
        chk_word("R10", win(w2, w3, 1));
        rx_order_req = 1'b0;
    endtask

    // Not armed, latency and control mapping (R4, R9)
    task automatic t_unarmed();
        wvec_t w1, w2;
        do_reset(PAT, PADA, 1'b0, 1'b1);
        w1 = mkw(8'h90); w1[2] = PAT; w1[3] = {1'b1, 8'h55};
        w2 = mkw(8'hA0);
        step(w1);
        chk_word("R4", w1);
        chk_bit("R4", ord_status, 1'b0);
        checks++;
        if (ord_ctrl !== 4'b1100 || ord_data[3*DW +: DW] !== 8'h55) begin
            failures++;
            $display("FAIL R9 ctrl=%b d3=%h exp ctrl=1100 d3=55", ord_ctrl, ord_data[3*DW +: DW]);
        end
        step(w2);
        chk_word("R9", w2);
    endtask

    // Sync-sourced arming (R3)
    task automatic t_sync();
        wvec_t w1, w2, e;
        do_reset(PAT, PADA, 1'b1, 1'b1);
        rx_order_req = 1'b1;
        step(mkw(8'h10));
        w1 = mkw(8'h14); w1[1] = PAT;
        step(w1);
        chk_word("R3", w1);
        chk_bit("R3", ord_status, 1'b0);
        rx_sync = 1'b1;
        step(mkw(8'h18));
        w2 = mkw(8'h1C); w2[1] = PAT;
        step(w2);
        for (int j = 0; j < NSYM; j++) e[j] = (j >= 1) ? PADA : w2[j];
        chk_word("R3", e);
        chk_bit("R3", ord_status, 1'b1);
        rx_order_req = 1'b0;
        rx_sync = 1'b0;
    endtask

    // Comparison width (R8)
    task automatic t_cmp();
        wvec_t w1, w2, e;
        do_reset(PAT, PADA, 1'b0, 1'b0);
        rx_order_req = 1'b1;
        step(mkw(8'h10));
        w1 = mkw(8'h20); w1[2] = {1'b0, PAT[7:0]};
        step(w1);
        for (int j = 0; j < NSYM; j++) e[j] = (j >= 2) ? PADA : w1[j];
        chk_word("R8", e);
        chk_bit("R8", ord_status, 1'b1);
        do_reset(PAT, PADA, 1'b0, 1'b1);
        rx_order_req = 1'b1;
        step(mkw(8'h10));
        step(w1);
        chk_word("R8", w1);
        chk_bit("R8", ord_status, 1'b0);
        w2 = mkw(8'h30); w2[1] = PAT;
        step(w2);
        for (int j = 0; j < NSYM; j++) e[j] = (j >= 1) ? PADA : w2[j];
        chk_word("R8", e);
        rx_order_req = 1'b0;
    endtask

    // Configuration captured at reset only (R1)
    task automatic t_cfg();
        wvec_t w1, e;
        do_reset(PAT, PADA, 1'b0, 1'b1);
        cfg_pad = PADB;
        cfg_pattern = 9'h1FB;
        cfg_sync_mode = 1'b1;
        rx_order_req = 1'b1;
        step(mkw(8'h10));
        w1 = mkw(8'h20); w1[1] = PAT;
        step(w1);
        for (int j = 0; j < NSYM; j++) e[j] = (j >= 1) ? PADA : w1[j];
        chk_word("R1", e);
        rx_order_req = 1'b0;
    endtask

    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        for (int k = 0; k < NSYM; k++) t_offset(k);
        t_rearm();
        t_unarmed();
        t_sync();
        t_cmp();
        t_cfg();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule